// File: doc/BRIEF.md
# Multidrop Address-Filtering Serial Receiver

This block is the receive side of a slave node that shares one serial line with many other nodes. Every character on the line carries nine bits. The last bit tags the character as either a node address or a payload byte. The node compares each address character with its own address. That address is a static input, typically wired to switches, and it differs on every node. Payload is passed on only while the most recent valid address matched.

Payload bytes leave the block on a byte-wide output with a one-cycle valid pulse. A flag shows whether the current message belongs to this node. Timing comes from an external oversampling enable, `tick`, with `OVS` ticks to one bit period. A character whose stop bit reads low is dropped and reported on a one-cycle error pulse.

Top module: `mdrop_rx`

## Requirements
- R1: After reset `selected`, `rx_valid` and `frame_err` are all 0.
- R2: A character is a low start bit, then nine bits sent least significant first, then a high stop bit. Each bit lasts `OVS` ticks. The ninth bit, sent last, is the tag: 1 means address and 0 means data.
- R3: A tagged character whose low eight bits equal `node_addr` sets `selected` to 1. If `selected` is already 1, it stays 1.
- R4: While `selected` is 0, data characters produce no `rx_valid` pulse. This holds even when a data value equals `node_addr`.
- R5: A tagged character that does not equal `node_addr` clears `selected`. Data characters after it are dropped.
- R6: While `selected` is 1, each data character gives exactly one single-cycle `rx_valid` pulse, with its low eight bits on `rx_data`. `rx_data` holds its value between pulses.
- R7: A character whose stop bit samples low gives a single-cycle `frame_err` pulse. It gives no `rx_valid` pulse and leaves `selected` unchanged, even when it is tagged and matching.
- R8: A low pulse on an idle line that is shorter than half a bit period is not taken as a start bit.
- R9: After a character ends with the line low, no new start is searched for until the line has gone high. A long break therefore reports a single `frame_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, `OVS` per bit period |
| rxd | input | 1 | Serial line, idles high |
| node_addr | input | 8 | This node's static address |
| rx_data | output | 8 | Last delivered payload byte |
| rx_valid | output | 1 | One-cycle strobe for a delivered byte |
| selected | output | 1 | Current message is addressed to this node |
| frame_err | output | 1 | One-cycle pulse for a character with a bad stop bit |

## Verification
The bench sends a data character equal to the node address while deselected. A design that ignored the tag bit would select itself on that character or leak the byte. It sends tagged characters with a low stop bit and matching addresses. A design that acted before checking the stop bit would change `selected` or deliver the byte. A short low glitch and a long break are also applied. A receiver without a mid-start check would produce a phantom character. A receiver that restarts on a low level rather than on a falling edge would report a stream of framing errors. The bench also deselects the node with a neighbouring address and sends payload bytes with the first and last bits set. This catches a wrong bit order or an address comparison that ignores some bits.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 1;

  typedef enum logic [2:0] {
    S_MARK, S_HUNT, S_START, S_BITS, S_STOP
  } rx_state_t;

  function automatic logic is_addr(input logic [FRAME_W-1:0] w);
    return w[FRAME_W-1];
  endfunction

  function automatic logic addr_match(input logic [FRAME_W-1:0] w,
                                      input logic [DATA_W-1:0]  node);
    return w[FRAME_W-1] && (w[DATA_W-1:0] == node);
  endfunction
endpackage

// File: rtl/mdrop_sync.sv
module mdrop_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0] st;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= 2'b11;
    else        st <= {st[0], din};
  end
  assign dout = st[1];
endmodule

// File: rtl/mdrop_deser.sv
module mdrop_deser
  import mdrop_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               rxd_s,
  output logic               frm_done,
  output logic [FRAME_W-1:0] frm_word,
  output logic               frm_stop_ok
);
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(FRAME_W - 1);

  rx_state_t          state;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      nbit;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_MARK;
      cnt         <= '0;
      nbit        <= '0;
      shreg       <= '0;
      frm_done    <= 1'b0;
      frm_stop_ok <= 1'b0;
    end else begin
      frm_done <= 1'b0;
      if (tick) begin
        unique case (state)
          S_MARK: if (rxd_s) state <= S_HUNT;
          S_HUNT: if (!rxd_s) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              nbit <= '0;
              state <= rxd_s ? S_HUNT : S_BITS;
            end else cnt <= cnt + 1'b1;
          end
          S_BITS: begin
            if (cnt == LAST) begin
              cnt   <= '0;
              shreg <= {rxd_s, shreg[FRAME_W-1:1]};
              if (nbit == LASTBIT) state <= S_STOP;
              else                 nbit  <= nbit + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt         <= '0;
              frm_done    <= 1'b1;
              frm_stop_ok <= rxd_s;
              state       <= rxd_s ? S_HUNT : S_MARK;
            end else cnt <= cnt + 1'b1;
          end
          default: state <= S_MARK;
        endcase
      end
    end
  end

  assign frm_word = shreg;
endmodule

// File: rtl/mdrop_filter.sv
module mdrop_filter
  import mdrop_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_done,
  input  logic [FRAME_W-1:0] frm_word,
  input  logic               frm_stop_ok,
  input  logic [DATA_W-1:0]  node_addr,
  output logic [DATA_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               selected,
  output logic               frame_err,
  output logic               addr_evt
);
  assign addr_evt = frm_done && frm_stop_ok && is_addr(frm_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      selected  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      if (frm_done) begin
        if (!frm_stop_ok) begin
          frame_err <= 1'b1;
        end else if (is_addr(frm_word)) begin
          selected <= addr_match(frm_word, node_addr);
        end else if (selected) begin
          rx_valid <= 1'b1;
          rx_data  <= frm_word[DATA_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [DATA_W-1:0] node_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              selected,
  output logic              frame_err
);
  logic               rxd_s;
  logic               frm_done;
  logic [FRAME_W-1:0] frm_word;
  logic               frm_stop_ok;
  logic               addr_evt;

  mdrop_sync u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  mdrop_deser #(.OVS(OVS)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s),
    .frm_done(frm_done), .frm_word(frm_word), .frm_stop_ok(frm_stop_ok)
  );

  mdrop_filter u_filter (
    .clk(clk), .rst_n(rst_n),
    .frm_done(frm_done), .frm_word(frm_word), .frm_stop_ok(frm_stop_ok),
    .node_addr(node_addr),
    .rx_data(rx_data), .rx_valid(rx_valid), .selected(selected),
    .frame_err(frame_err), .addr_evt(addr_evt)
  );
endmodule

// File: rtl/mdrop_rx_chk.sv
module mdrop_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       selected,
  input logic       frame_err,
  input logic       frm_done,
  input logic       frm_stop_ok,
  input logic       addr_evt
);
  AST_VALID_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> selected); // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R6

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_valid); // R6

  AST_SEL_ON_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(selected) |-> $past(addr_evt)); // R5

  AST_ERR_FROM_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(frm_done) && !$past(frm_stop_ok))); // R7

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err && rx_valid)); // R7
endmodule

bind mdrop_rx mdrop_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .selected(selected), .frame_err(frame_err), .frm_done(frm_done),
  .frm_stop_ok(frm_stop_ok), .addr_evt(addr_evt)
);

// File: tb/mdrop_rx_test.sv
module mdrop_rx_test;
  localparam int OVS  = 8;
  localparam int BITC = 2 * OVS;
  localparam logic [7:0] NODE = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, selected, frame_err;

  int compared = 0;
  int mismatched = 0;
  int err_seen = 0;
  int exp_err = 0;
  bit model_sel = 1'b0;
  logic [7:0] last_data = 8'h00;
  logic [7:0] expq[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  mdrop_rx #(.OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .node_addr(NODE),
    .rx_data(rx_data), .rx_valid(rx_valid), .selected(selected),
    .frame_err(frame_err)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      compared++;
      if (expq.size() == 0) begin
        mismatched++;
        $display("FAIL R4/R6: unexpected byte actual %0h expected none", rx_data);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if (rx_data != e) begin
          mismatched++;
          $display("FAIL R2/R6: byte actual %0h expected %0h", rx_data, e);
        end
      end
    end
    if (rst_n && frame_err) err_seen++;
  end

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [8:0] w, input logic stop);
    hold(1'b0, BITC);
    for (int i = 0; i < 9; i++) hold(w[i], BITC);
    hold(stop, BITC);
    hold(1'b1, 3 * BITC);
  endtask

  task automatic after_frame(input string req);
    check({req, " selected"}, selected, model_sel);
    check({req, " queue drained"}, expq.size(), 0);
    check({req, " frame_err count"}, err_seen, exp_err);
  endtask

  task automatic send_addr(input logic [7:0] a, input string req);
    send_frame({1'b1, a}, 1'b1);
    model_sel = (a == NODE);
    after_frame(req);
  endtask

  task automatic send_data(input logic [7:0] d, input string req);
    if (model_sel) begin
      expq.push_back(d);
      last_data = d;
    end
    send_frame({1'b0, d}, 1'b1);
    after_frame(req);
    check({req, " rx_data held"}, rx_data, last_data);
  endtask

  task automatic send_bad(input logic [8:0] w, input string req);
    send_frame(w, 1'b0);
    exp_err++;
    after_frame(req);
    check({req, " rx_data held"}, rx_data, last_data);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 selected", selected, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 frame_err", frame_err, 0);
    hold(1'b1, BITC);

    send_data(8'h11, "R4 unselected");
    send_data(NODE, "R4 data equal to address");
    send_addr(8'h33, "R5 foreign address");
    send_addr(NODE, "R3 own address");
    send_data(8'h01, "R2 lsb");
    send_data(8'h80, "R2 msb");
    send_data(8'hA5, "R6 pattern");
    send_data(8'h00, "R6 zero");
    send_data(8'hFF, "R6 ones");
    send_bad({1'b0, 8'h77}, "R7 bad data stop");

    hold(1'b0, 2);
    hold(1'b1, 4 * BITC);
    after_frame("R8 glitch");
    send_data(8'h3C, "R8 after glitch");

    hold(1'b0, 30 * BITC);
    exp_err++;
    hold(1'b1, 3 * BITC);
    after_frame("R9 break");
    send_data(8'hC3, "R9 after break");

    send_addr(8'h5B, "R5 neighbour address");
    send_data(8'h44, "R5 dropped");
    send_bad({1'b1, NODE}, "R7 bad address stop");
    send_addr(NODE, "R3 reselect");
    send_addr(NODE, "R3 repeat");
    send_data(8'h99, "R6 after reselect");
    summary();
  end
endmodule